// File: doc/BRIEF.md
# Pipelined RC4 Keystream Stream Cipher

The block enciphers or deciphers a stream of words with the RC4 output loop. Each accepted input word is XORed with one keystream word. The permutation table, with 2^WORD_W entries, is held inside the block together with the two state indices I and J. Words enter and leave over valid/ready handshakes. The same operation serves both directions, because applying the XOR twice restores the plaintext.

Before streaming, a host writes a key-scheduled table through a table load port, one entry per cycle. It sets the starting indices through an index load strobe. The current I and J can always be read from the state outputs. They keep their values between messages, so the next message continues the same keystream.

One iteration is spread over two register stages. A new word reads the table while the swap of the word ahead of it is still pending. Comparing the indices and forwarding the pending swap values keeps every result equal to that of a strictly sequential loop. No cycle is lost to these hazards.

Top module: `rc4_stream_engine`

## Requirements
- R1: While reset is high, and in the first cycle after reset, stateI and stateJ are 0 and outValid is 0. Table contents are not reset.
- R2: A cycle with tabLoadEn high writes tabLoadData into table entry tabLoadAddr. Every later keystream word is computed from the loaded entries.
- R3: A cycle with idxLoadEn high sets stateI to idxLoadI and stateJ to idxLoadJ from the next cycle on.
- R4: For each accepted word, the block performs these steps, all modulo 2^WORD_W. First si = S[I], then J = J + si, then sj = S[J], then T = si + sj. It then swaps S[I] and S[J]. The output is the input XOR S[T], read after that swap. Finally I = I + 1.
- R5: When a word's new J equals the I of the word just before it, or its reads hit any entry that the previous word swaps, the results equal those of the sequential loop.
- R6: Outputs leave in input order, exactly one per accepted input. While outValid is high and outReady is low, outValid stays high and outData stays unchanged.
- R7: When no load strobe is high and the output register is empty or being taken, inReady is high. The block then sustains one word per cycle.
- R8: Each accepted word advances stateI by exactly 1 in the next cycle. stateI and stateJ show the indices after the last accepted word as soon as it is accepted.
- R9: Cycles with no accepted word and no index load leave stateI, stateJ and the table unchanged. A later message continues the keystream exactly.
- R10: While tabLoadEn or idxLoadEn is high, inReady is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Block takes the input word at this edge |
| inData | input | WORD_W | Plaintext or ciphertext word |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Consumer takes the output word |
| outData | output | WORD_W | Input word XOR keystream word |
| tabLoadEn | input | 1 | Write one table entry |
| tabLoadAddr | input | WORD_W | Table entry to write |
| tabLoadData | input | WORD_W | Value written to the entry |
| idxLoadEn | input | 1 | Load the starting indices |
| idxLoadI | input | WORD_W | New value of I |
| idxLoadJ | input | WORD_W | New value of J |
| stateI | output | WORD_W | Current index I |
| stateJ | output | WORD_W | Current index J |

## Verification
The bench builds the block with its default WORD_W of 8, which is the full 256-entry table. The bench loads tables that need not be permutations. One of them holds only the values 0, 1 and 2, so J creeps along just behind I and lands on the previous word's I again and again. This makes the forwarding paths fire hundreds of times in a single message. Random gaps on inValid and random outReady stalls put the pending swap in the second stage in every alignment with the new word's reads.

// File: rtl/rc4_pkg.sv
package rc4_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic advance;   // pipeline registers move this cycle
    logic accept;    // an input word enters stage one
    logic commit;    // the pending swap is written to the table
    logic tabWrite;  // host writes one table entry
    logic idxWrite;  // host writes I and J
  } rc4_strobe_t;

endpackage

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
  import rc4_pkg::*;
(
  input  logic        inValid,
  input  logic        outReady,
  input  logic        bValid,
  input  logic        cValid,
  input  logic        tabLoadEn,
  input  logic        idxLoadEn,
  output logic        inReady,
  output rc4_strobe_t stb
);

  logic advance;
  logic loadBusy;

  always_comb begin
    // The whole pipeline moves only when the output slot is free or taken
    advance  = !cValid || outReady;
    loadBusy = tabLoadEn || idxLoadEn;
    inReady  = advance && !loadBusy;

    stb.advance  = advance;
    stb.accept   = inValid && inReady;
    stb.commit   = advance && bValid;
    stb.tabWrite = tabLoadEn;
    stb.idxWrite = idxLoadEn;
  end

endmodule

// File: rtl/rc4_datapath.sv
module rc4_datapath
  import rc4_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rc4_strobe_t       stb,
  input  logic [WORD_W-1:0] inData,
  input  logic [WORD_W-1:0] tabLoadAddr,
  input  logic [WORD_W-1:0] tabLoadData,
  input  logic [WORD_W-1:0] idxLoadI,
  input  logic [WORD_W-1:0] idxLoadJ,
  output logic              bValid,
  output logic              cValid,
  output logic [WORD_W-1:0] cData,
  output logic [WORD_W-1:0] idxI,
  output logic [WORD_W-1:0] idxJ
);

  localparam int DEPTH = 1 << WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  word_t tbl [DEPTH];

  // Stage two: an iteration whose swap is not yet in the table
  word_t bI, bJ, bSi, bSj, bT, bData;

  // Stage one (combinational on the incoming word)
  word_t aSi, aJ, aSj, aT;
  // Stage two keystream word
  word_t bKs;

  // Table read as seen after the pending swap of stage two
  function automatic word_t viewAfterSwap(
    input word_t addr, input word_t raw, input logic pend,
    input word_t pI, input word_t pJ, input word_t pSi, input word_t pSj);
    word_t r;
    if (pend && addr == pJ)      r = pSi;
    else if (pend && addr == pI) r = pSj;
    else                         r = raw;
    return r;
  endfunction

  always_comb begin
    aSi = viewAfterSwap(idxI, tbl[idxI], bValid, bI, bJ, bSi, bSj);
    aJ  = idxJ + aSi;
    aSj = viewAfterSwap(aJ, tbl[aJ], bValid, bI, bJ, bSi, bSj);
    aT  = aSi + aSj;
    // The output read sees this iteration's own swap
    bKs = viewAfterSwap(bT, tbl[bT], 1'b1, bI, bJ, bSi, bSj);
  end

  // Index registers and pipeline valid bits
  always_ff @(posedge clk) begin
    if (rst) begin
      idxI   <= '0;
      idxJ   <= '0;
      bValid <= 1'b0;
      cValid <= 1'b0;
    end else begin
      if (stb.idxWrite) begin
        idxI <= idxLoadI;
        idxJ <= idxLoadJ;
      end else if (stb.accept) begin
        idxI <= idxI + 1'b1;
        idxJ <= aJ;
      end
      if (stb.advance) begin
        bValid <= stb.accept;
        cValid <= bValid;
      end
    end
  end

  // Pipeline payload registers
  always_ff @(posedge clk) begin
    if (stb.advance) begin
      if (stb.accept) begin
        bI    <= idxI;
        bJ    <= aJ;
        bSi   <= aSi;
        bSj   <= aSj;
        bT    <= aT;
        bData <= inData;
      end
      if (bValid) cData <= bData ^ bKs;
    end
  end

  // Table: swap commit, then host load (host load wins on the same entry)
  always_ff @(posedge clk) begin
    if (stb.commit) begin
      tbl[bI] <= bSj;
      tbl[bJ] <= bSi;
    end
    if (stb.tabWrite) tbl[tabLoadAddr] <= tabLoadData;
  end

endmodule

// File: rtl/rc4_stream_engine.sv
module rc4_stream_engine
  import rc4_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outData,
  input  logic              tabLoadEn,
  input  logic [WORD_W-1:0] tabLoadAddr,
  input  logic [WORD_W-1:0] tabLoadData,
  input  logic              idxLoadEn,
  input  logic [WORD_W-1:0] idxLoadI,
  input  logic [WORD_W-1:0] idxLoadJ,
  output logic [WORD_W-1:0] stateI,
  output logic [WORD_W-1:0] stateJ
);

  rc4_strobe_t stb;
  logic        bValid;
  logic        cValid;

  rc4_ctrl uCtrl (
    .inValid  (inValid),
    .outReady (outReady),
    .bValid   (bValid),
    .cValid   (cValid),
    .tabLoadEn(tabLoadEn),
    .idxLoadEn(idxLoadEn),
    .inReady  (inReady),
    .stb      (stb)
  );

  rc4_datapath #(.WORD_W(WORD_W)) uPath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .inData     (inData),
    .tabLoadAddr(tabLoadAddr),
    .tabLoadData(tabLoadData),
    .idxLoadI   (idxLoadI),
    .idxLoadJ   (idxLoadJ),
    .bValid     (bValid),
    .cValid     (cValid),
    .cData      (outData),
    .idxI       (stateI),
    .idxJ       (stateJ)
  );

  assign outValid = cValid;

endmodule

// File: rtl/rc4_stream_checker.sv
module rc4_stream_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData,
  input logic              tabLoadEn,
  input logic              idxLoadEn,
  input logic [WORD_W-1:0] idxLoadI,
  input logic [WORD_W-1:0] idxLoadJ,
  input logic [WORD_W-1:0] stateI,
  input logic [WORD_W-1:0] stateJ
);

  // Words accepted but not yet delivered
  logic [2:0] inFlight;
  logic       inFire;
  logic       outFire;

  assign inFire  = inValid && inReady;
  assign outFire = outValid && outReady;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + {2'b0, inFire} - {2'b0, outFire};
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stateI == '0 && stateJ == '0 && !outValid));

  a_r3_index_load: assert property (@(posedge clk) disable iff (rst)
    idxLoadEn |=> (stateI == $past(idxLoadI) && stateJ == $past(idxLoadJ)));

  a_r6_hold_output: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r6_in_flight_bound: assert property (@(posedge clk) disable iff (rst)
    inFlight <= 3'd2);

  a_r6_no_output_when_empty: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inFlight != 3'd0);

  a_r8_index_step: assert property (@(posedge clk) disable iff (rst)
    inFire |=> stateI == WORD_W'($past(stateI) + 1'b1));

  a_r9_idle_state: assert property (@(posedge clk) disable iff (rst)
    (!inFire && !idxLoadEn) |=> ($stable(stateI) && $stable(stateJ)));

  a_r10_load_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (tabLoadEn || idxLoadEn) |-> !inReady);

endmodule

bind rc4_stream_engine rc4_stream_checker #(.WORD_W(WORD_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .tabLoadEn(tabLoadEn),
  .idxLoadEn(idxLoadEn),
  .idxLoadI (idxLoadI),
  .idxLoadJ (idxLoadJ),
  .stateI   (stateI),
  .stateJ   (stateJ)
);

// File: tb/tb_rc4_stream_engine.sv
module tb_rc4_stream_engine;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 8;
  localparam int DEPTH      = 1 << WORD_W;
  localparam int MASK       = DEPTH - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [WORD_W-1:0] inData = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [WORD_W-1:0] outData;
  logic              tabLoadEn = 1'b0;
  logic [WORD_W-1:0] tabLoadAddr = '0;
  logic [WORD_W-1:0] tabLoadData = '0;
  logic              idxLoadEn = 1'b0;
  logic [WORD_W-1:0] idxLoadI = '0;
  logic [WORD_W-1:0] idxLoadJ = '0;
  logic [WORD_W-1:0] stateI;
  logic [WORD_W-1:0] stateJ;

  rc4_stream_engine #(.WORD_W(WORD_W)) dut (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .tabLoadEn(tabLoadEn), .tabLoadAddr(tabLoadAddr), .tabLoadData(tabLoadData),
    .idxLoadEn(idxLoadEn), .idxLoadI(idxLoadI), .idxLoadJ(idxLoadJ),
    .stateI(stateI), .stateJ(stateJ)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    total = 0;
  int    bad = 0;
  int    refS [DEPTH];
  int    ksa [DEPTH];
  int    refI = 0;
  int    refJ = 0;
  int    expQ [$];
  int    hazards = 0;
  bit    prevStall = 0;
  int    prevOut = 0;
  string phaseTag = "R4";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Sequential reference of one iteration
  task automatic modelStep(input int d);
    int si, sj, t;
    si   = refS[refI];
    refJ = (refJ + si) & MASK;
    if (refJ == ((refI - 1) & MASK)) hazards++;
    sj   = refS[refJ];
    t    = (si + sj) & MASK;
    refS[refI] = sj;
    refS[refJ] = si;
    expQ.push_back((d ^ refS[t]) & MASK);
    refI = (refI + 1) & MASK;
  endtask

  // One cycle: drive at the falling edge, compare just after
  task automatic tick(input bit iv, input int d, input bit ordy, output bit acc);
    int e;
    @(negedge clk);
    inValid  = iv;
    inData   = d[WORD_W-1:0];
    outReady = ordy;
    #1;
    check(int'(stateI) == refI, "R8 stateI", int'(stateI), refI);
    check(int'(stateJ) == refJ, "R8 stateJ", int'(stateJ), refJ);
    if (prevStall)
      check(outValid && int'(outData) == prevOut, "R6 stalled output held",
            int'(outData), prevOut);
    if (outValid && outReady) begin
      if (expQ.size() == 0) check(1'b0, "R6 output without input", int'(outData), -1);
      else begin
        e = expQ.pop_front();
        check(int'(outData) == e, phaseTag, int'(outData), e);
      end
    end
    prevStall = outValid && !outReady;
    prevOut   = int'(outData);
    acc = inValid && inReady;
    if (acc) modelStep(d & MASK);
  endtask

  task automatic drain();
    bit acc;
    repeat (4) tick(1'b0, 0, 1'b1, acc);
    check(expQ.size() == 0, "R6 one output per input", expQ.size(), 0);
  endtask

  // Message with optional random input gaps and output stalls
  task automatic sendMsg(input int n, input bit gaps, input bit stalls);
    int  sent = 0;
    int  d;
    bit  acc;
    bit  iv;
    bit  rdy;
    d = $urandom & MASK;
    while (sent < n) begin
      iv  = gaps ? (($urandom % 4) != 0) : 1'b1;
      rdy = stalls ? (($urandom % 3) != 0) : 1'b1;
      tick(iv, d, rdy, acc);
      if (acc) begin
        sent++;
        d = $urandom & MASK;
      end
    end
    drain();
  endtask

  function automatic int tableVal(input int mode, input int a);
    case (mode)
      0:       return a;
      1:       return (a * 167 + 13) & MASK;
      2:       return (a * 7) % 3;
      default: return ksa[a];
    endcase
  endfunction

  task automatic loadTable(input int mode);
    drain();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      tabLoadEn   = 1'b1;
      tabLoadAddr = a[WORD_W-1:0];
      tabLoadData = tableVal(mode, a)[WORD_W-1:0];
      inValid     = 1'b1;
      #1;
      if (a == 0) check(!inReady, "R10 table load blocks input", int'(inReady), 0);
      refS[a] = tableVal(mode, a);
    end
    @(negedge clk);
    tabLoadEn = 1'b0;
    inValid   = 1'b0;
    prevStall = 0;
  endtask

  task automatic loadIdx(input int i, input int j);
    @(negedge clk);
    idxLoadEn = 1'b1;
    idxLoadI  = i[WORD_W-1:0];
    idxLoadJ  = j[WORD_W-1:0];
    inValid   = 1'b1;
    #1;
    check(!inReady, "R10 index load blocks input", int'(inReady), 0);
    @(negedge clk);
    idxLoadEn = 1'b0;
    inValid   = 1'b0;
    #1;
    check(int'(stateI) == i, "R3 stateI after load", int'(stateI), i);
    check(int'(stateJ) == j, "R3 stateJ after load", int'(stateJ), j);
    refI = i;
    refJ = j;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int  keyBytes [5] = '{8'h3b, 8'h91, 8'h07, 8'hc4, 8'h5e};
    int  jj;
    int  tmp;
    int  saveI;
    int  saveJ;
    bit  acc;

    // Key schedule computed behaviourally for a realistic table
    for (int a = 0; a < DEPTH; a++) ksa[a] = a;
    jj = 0;
    for (int a = 0; a < DEPTH; a++) begin
      jj = (jj + ksa[a] + keyBytes[a % 5]) & MASK;
      tmp = ksa[a]; ksa[a] = ksa[jj]; ksa[jj] = tmp;
    end

    repeat (5) @(negedge clk);
    #1;
    check(stateI == '0 && stateJ == '0, "R1 indices in reset", int'(stateI), 0);
    check(!outValid, "R1 outValid in reset", int'(outValid), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(stateI == '0 && stateJ == '0, "R1 indices after reset", int'(stateJ), 0);
    check(!outValid, "R1 outValid after reset", int'(outValid), 0);

    // Identity table, random gaps and stalls
    phaseTag = "R2/R4 identity table keystream";
    loadTable(0);
    loadIdx(0, 0);
    sendMsg(300, 1'b1, 1'b1);

    // Zero-length message, then continuation
    saveI = int'(stateI);
    saveJ = int'(stateJ);
    repeat (12) tick(1'b0, 0, 1'b1, acc);
    check(int'(stateI) == saveI, "R9 idle keeps I", int'(stateI), saveI);
    check(int'(stateJ) == saveJ, "R9 idle keeps J", int'(stateJ), saveJ);
    phaseTag = "R9 continued keystream";
    sendMsg(100, 1'b0, 1'b1);

    // Key-scheduled table, full-rate burst
    phaseTag = "R4 key-scheduled keystream";
    loadTable(3);
    loadIdx(0, 0);
    for (int k = 0; k < 64; k++) begin
      tick(1'b1, (k * 29 + 5) & MASK, 1'b1, acc);
      check(acc, "R7 one word per cycle", int'(acc), 1);
    end
    drain();

    // Hazard-heavy table: J trails I closely
    phaseTag = "R5 hazard forwarding keystream";
    hazards = 0;
    loadTable(2);
    loadIdx(2, 0);
    sendMsg(400, 1'b0, 1'b0);
    sendMsg(400, 1'b1, 1'b1);
    check(hazards > 20, "R5 hazards exercised", hazards, 21);

    // Permutation table, odd starting indices
    phaseTag = "R4/R5 permutation keystream";
    loadTable(1);
    loadIdx(200, 17);
    sendMsg(300, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule